// File: doc/BRIEF.md
# Next-PC and Link Logic

This unit decides where a 16-bit processor fetches next after a control-flow instruction. Each cycle it receives the already-incremented PC, the instruction word, the value read from the register file for the base-register field, and the current sign flags. From these it produces the next fetch address, a redirect strobe, and a write request that stores a return address in the link register (R7). It covers conditional branches, subroutine calls in two addressing modes, register jumps (including return through R7) and system calls routed through a table of service-routine addresses in the lowest 256 words of memory.

A system call takes two cycles. In the first, the unit asks memory for the table word at the vector's address and writes the return address to R7. In the second, the unit presents that word as the next PC and raises `busy`, which tells the fetch stage that no new instruction is accepted. All other instructions resolve combinationally in the cycle they are presented. An instruction that is not a control transfer, and a branch that is not taken, leave the next PC at the incremented value.

Top module: `npc_link_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it with no instruction presented, `busy`, `redirect`, `link_we` and `vec_req` are all 0.
- R2: A branch (instr[15:12] = 0000) whose mask instr[11:9] (bit 11 = negative, bit 10 = zero, bit 9 = positive) shares a set bit with `flags` ({N,Z,P}, bit 2 = N) gives `redirect` = 1 and `next_pc` = `pc_inc` + sign-extended instr[8:0]; when no masked flag is set, `redirect` = 0 and `next_pc` = `pc_inc`.
- R3: A branch with mask 000 is never taken, whatever the flags; a branch with mask 111 is always taken.
- R4: A call (instr[15:12] = 0100) with instr[11] = 1 gives `redirect` = 1, `next_pc` = `pc_inc` + sign-extended instr[10:0], `link_we` = 1 and `link_data` = `pc_inc`.
- R5: A call with instr[11] = 0 gives `redirect` = 1, `next_pc` = `base_val`, `link_we` = 1 and `link_data` = `pc_inc`; when the base register is R7 the target is still the old `base_val`.
- R6: A jump (instr[15:12] = 1100), including return with base R7, gives `redirect` = 1, `next_pc` = `base_val` and `link_we` = 0.
- R7: In the first cycle of a system call (instr[15:12] = 1111) the unit gives `vec_req` = 1, `vec_addr` = instr[7:0] zero-extended, `link_we` = 1, `link_data` = `pc_inc` and `redirect` = 0.
- R8: In the cycle after a system call is accepted, `busy` = 1, `redirect` = 1, `next_pc` = `vec_data`, and `busy` falls again the cycle after.
- R9: While `busy` is 1 the instruction inputs are ignored: `link_we` and `vec_req` stay 0 and `next_pc` is `vec_data`.
- R10: Any other opcode gives `redirect` = 0, `link_we` = 0, `vec_req` = 0 and `next_pc` = `pc_inc`.
- R11: With `instr_valid` = 0 and not busy, `redirect`, `link_we` and `vec_req` are 0 and `next_pc` = `pc_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| pc_inc | input | ADDR_W | Address of the instruction after this one |
| base_val | input | ADDR_W | Register file value selected by instr[8:6] |
| flags | input | 3 | {N,Z,P} condition flags |
| vec_data | input | ADDR_W | Table word returned one cycle after `vec_req` |
| next_pc | output | ADDR_W | Next fetch address |
| redirect | output | 1 | Control transfer this cycle |
| link_we | output | 1 | Write `link_data` to R7 |
| link_data | output | ADDR_W | Return address for R7 |
| vec_req | output | 1 | Read request to the service-routine table |
| vec_addr | output | ADDR_W | Table entry address |
| busy | output | 1 | Second cycle of a system call; fetch must stall |

## Verification
The embedded properties assume that exactly one of the three flags is set whenever reset is released, and that the memory answers a table read in the very next cycle so `vec_data` is meaningful while `busy` is high. The bench draws flags only from the three one-hot values and supplies a fresh table word every cycle, so the busy-cycle comparison always has a defined expected address. Random stimulus mixes the four control classes with arbitrary other opcodes and idle cycles, and directed cases cover empty and full branch masks, calls and jumps through R7, and a system call followed by an instruction offered during the stall.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int INSTR_W = 16;
   localparam int VEC_W   = 8;

   typedef enum logic [3:0] {
      OPC_BRANCH = 4'b0000,
      OPC_CALL   = 4'b0100,
      OPC_JUMP   = 4'b1100,
      OPC_SYSC   = 4'b1111
   } opcode_e;

   typedef enum logic [2:0] {
      CK_NONE,
      CK_BRANCH,
      CK_CALL_REL,
      CK_CALL_REG,
      CK_JUMP,
      CK_SYSC
   } ctl_kind_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic        valid,
   input  logic        hold,
   input  logic [6:0]  ir_hi,
   input  logic [2:0]  flags,
   input  logic        clk,
   input  logic        rst_n,
   output ctl_kind_e   kind,
   output logic        take
);

   logic [3:0] opc;
   logic [2:0] mask;

   assign opc  = ir_hi[6:3];
   assign mask = ir_hi[2:0];

   always_comb begin
      kind = CK_NONE;
      if (valid && !hold) begin
         unique case (opc)
            OPC_BRANCH: kind = CK_BRANCH;
            OPC_CALL:   kind = ir_hi[2] ? CK_CALL_REL : CK_CALL_REG;
            OPC_JUMP:   kind = CK_JUMP;
            OPC_SYSC:   kind = CK_SYSC;
            default:    kind = CK_NONE;
         endcase
      end
   end

   assign take = (kind == CK_BRANCH) && ((mask & flags) != 3'b000);

   // Input assumption: condition flags always carry exactly one set bit.
   assert_flags_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flags) == 1);

   // An empty mask can never produce a taken branch.
   assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CK_BRANCH && mask == 3'b000) |-> !take);

endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] pc_inc,
   input  logic [10:0]       ir_off,
   input  logic [ADDR_W-1:0] base_val,
   input  ctl_kind_e         kind,
   output logic [ADDR_W-1:0] target
);

   localparam int BR_OFF_W   = 9;
   localparam int CALL_OFF_W = 11;

   logic [ADDR_W-1:0] off_br;
   logic [ADDR_W-1:0] off_call;
   logic [ADDR_W-1:0] rel_sum;
   logic              use_reg;

   assign off_br   = {{(ADDR_W-BR_OFF_W){ir_off[BR_OFF_W-1]}},   ir_off[BR_OFF_W-1:0]};
   assign off_call = {{(ADDR_W-CALL_OFF_W){ir_off[CALL_OFF_W-1]}}, ir_off};
   assign use_reg  = (kind == CK_CALL_REG) || (kind == CK_JUMP);

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [ADDR_W-1:0] off_sel;
         assign off_sel = (kind == CK_CALL_REL) ? off_call : off_br;
         assign rel_sum = pc_inc + off_sel;
      end else begin : g_split
         logic [ADDR_W-1:0] sum_br;
         logic [ADDR_W-1:0] sum_call;
         assign sum_br   = pc_inc + off_br;
         assign sum_call = pc_inc + off_call;
         assign rel_sum  = (kind == CK_CALL_REL) ? sum_call : sum_br;
      end
   endgenerate

   assign target = use_reg ? base_val : rel_sum;

endmodule

// File: rtl/npc_trap_seq.sv
module npc_trap_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= start && !busy_q;
   end

   assign busy = busy_q;

   assert_start_then_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   assert_no_start_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: rtl/npc_link_unit.sv
module npc_link_unit
   import npc_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 instr_valid,
   input  logic [INSTR_W-1:0]   instr,
   input  logic [ADDR_W-1:0]    pc_inc,
   input  logic [ADDR_W-1:0]    base_val,
   input  logic [2:0]           flags,
   input  logic [ADDR_W-1:0]    vec_data,
   output logic [ADDR_W-1:0]    next_pc,
   output logic                 redirect,
   output logic                 link_we,
   output logic [ADDR_W-1:0]    link_data,
   output logic                 vec_req,
   output logic [ADDR_W-1:0]    vec_addr,
   output logic                 busy
);

   generate
      if (ADDR_W < 12 || ADDR_W > 32) begin : g_bad_width
         $error("npc_link_unit: ADDR_W must lie in 12..32");
      end
      if (VEC_W >= ADDR_W) begin : g_bad_vec
         $error("npc_link_unit: vector must be narrower than the address");
      end
   endgenerate

   ctl_kind_e         kind;
   logic              take;
   logic [ADDR_W-1:0] target;

   npc_decode u_decode (
      .valid (instr_valid),
      .hold  (busy),
      .ir_hi (instr[15:9]),
      .flags (flags),
      .clk   (clk),
      .rst_n (rst_n),
      .kind  (kind),
      .take  (take)
   );

   npc_target #(
      .ADDR_W       (ADDR_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_target (
      .pc_inc   (pc_inc),
      .ir_off   (instr[10:0]),
      .base_val (base_val),
      .kind     (kind),
      .target   (target)
   );

   npc_trap_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (vec_req),
      .busy  (busy)
   );

   always_comb begin
      next_pc  = pc_inc;
      redirect = 1'b0;
      if (busy) begin
         next_pc  = vec_data;
         redirect = 1'b1;
      end else begin
         unique case (kind)
            CK_BRANCH: begin
               redirect = take;
               if (take) next_pc = target;
            end
            CK_CALL_REL, CK_CALL_REG, CK_JUMP: begin
               redirect = 1'b1;
               next_pc  = target;
            end
            default: ;
         endcase
      end
   end

   assign link_we   = (kind == CK_CALL_REL) || (kind == CK_CALL_REG) || (kind == CK_SYSC);
   assign link_data = pc_inc;
   assign vec_req   = (kind == CK_SYSC);
   assign vec_addr  = {{(ADDR_W-VEC_W){1'b0}}, instr[VEC_W-1:0]};

   assert_vec_low_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> (vec_addr >> VEC_W) == '0);

   assert_sysc_no_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> (!redirect && link_we));

   assert_busy_loads_table_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (redirect && next_pc == vec_data));

   assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!link_we && !vec_req));

   assert_call_redirects_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (link_we && !vec_req) |-> redirect);

   assert_idle_sequential_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_valid && !busy) |-> (!redirect && !link_we && next_pc == pc_inc));

endmodule

// File: tb/npc_link_unit_tb.sv
module npc_link_unit_tb;

   localparam int AW = 16;
   localparam int WATCHDOG_CYC = 200000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          instr_valid;
   logic [15:0]   instr;
   logic [AW-1:0] pc_inc, base_val, vec_data;
   logic [2:0]    flags;
   logic [AW-1:0] next_pc, link_data, vec_addr;
   logic          redirect, link_we, vec_req, busy;

   int n_checks = 0;
   int n_fails  = 0;
   bit exp_busy = 1'b0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   npc_link_unit #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .pc_inc(pc_inc), .base_val(base_val), .flags(flags), .vec_data(vec_data),
      .next_pc(next_pc), .redirect(redirect), .link_we(link_we),
      .link_data(link_data), .vec_req(vec_req), .vec_addr(vec_addr), .busy(busy)
   );

   function automatic logic [15:0] sx9(input logic [8:0] v);
      return {{7{v[8]}}, v};
   endfunction

   function automatic logic [15:0] sx11(input logic [10:0] v);
      return {{5{v[10]}}, v};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [15:0] ir, input logic [15:0] pc,
                       input logic [15:0] bv, input logic [2:0] fl, input logic [15:0] vd);
      logic          e_red, e_lwe, e_vreq;
      logic [15:0]   e_npc;
      string         tag;
      @(negedge clk);
      instr_valid = v; instr = ir; pc_inc = pc; base_val = bv; flags = fl; vec_data = vd;
      #2;
      e_red = 1'b0; e_lwe = 1'b0; e_vreq = 1'b0; e_npc = pc; tag = "R11";
      if (exp_busy) begin
         e_red = 1'b1; e_npc = vd;
         tag = v ? "R9" : "R8";
      end else if (v) begin
         case (ir[15:12])
            4'b0000: begin
               tag = (ir[11:9] == 3'b000 || ir[11:9] == 3'b111) ? "R3" : "R2";
               if ((ir[11:9] & fl) != 3'b000) begin e_red = 1'b1; e_npc = pc + sx9(ir[8:0]); end
            end
            4'b0100: begin
               e_red = 1'b1; e_lwe = 1'b1;
               if (ir[11]) begin tag = "R4"; e_npc = pc + sx11(ir[10:0]); end
               else begin tag = "R5"; e_npc = bv; end
            end
            4'b1100: begin tag = "R6"; e_red = 1'b1; e_npc = bv; end
            4'b1111: begin tag = "R7"; e_lwe = 1'b1; e_vreq = 1'b1; end
            default: tag = "R10";
         endcase
      end
      chk(tag, "next_pc",  next_pc,  e_npc);
      chk(tag, "redirect", redirect, e_red);
      chk(tag, "link_we",  link_we,  e_lwe);
      chk(tag, "vec_req",  vec_req,  e_vreq);
      chk(tag, "busy",     busy,     exp_busy);
      if (e_lwe)  chk(tag, "link_data", link_data, pc);
      if (e_vreq) chk(tag, "vec_addr",  vec_addr,  {8'h00, ir[7:0]});
      exp_busy = !exp_busy && v && (ir[15:12] == 4'b1111);
   endtask

   function automatic logic [2:0] rand_flags();
      case ($urandom % 3)
         0: return 3'b100;
         1: return 3'b010;
         default: return 3'b001;
      endcase
   endfunction

   function automatic logic [15:0] rand_instr();
      logic [15:0] r;
      r = 16'($urandom);
      case ($urandom % 8)
         0, 1: r[15:12] = 4'b0000;
         2:    r[15:12] = 4'b0100;
         3:    r[15:12] = 4'b1100;
         4:    r[15:12] = 4'b1111;
         default: ;
      endcase
      return r;
   endfunction

   initial begin
      #(8 * WATCHDOG_CYC);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; instr_valid = 1'b0; instr = '0; pc_inc = 16'h3000;
      base_val = '0; flags = 3'b010; vec_data = '0;
      repeat (3) @(negedge clk);
      #2;
      chk("R1", "busy in reset", busy, 1'b0);
      chk("R1", "redirect in reset", redirect, 1'b0);
      chk("R1", "link_we in reset", link_we, 1'b0);
      chk("R1", "vec_req in reset", vec_req, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      step(1'b0, 16'hF025, 16'h3001, 16'h0, 3'b010, 16'h0);          // R1 / R11 idle after reset
      // R3 empty and full masks
      step(1'b1, 16'h01FF, 16'h3002, 16'h0, 3'b100, 16'h0);
      step(1'b1, 16'h0E05, 16'h3003, 16'h0, 3'b001, 16'h0);
      // R2 backward branch, zero flag, and not-taken case
      step(1'b1, 16'h05FC, 16'h3004, 16'h0, 3'b010, 16'h0);
      step(1'b1, 16'h0A10, 16'h3005, 16'h0, 3'b010, 16'h0);
      // R4 call relative, negative offset, wraparound
      step(1'b1, 16'h4FFF, 16'h0000, 16'h0, 3'b001, 16'h0);
      // R5 call through R7: target is the old register value
      step(1'b1, 16'h41C0, 16'h3010, 16'h4444, 3'b001, 16'h0);
      // R6 return through R7
      step(1'b1, 16'hC1C0, 16'h3011, 16'h3555, 3'b001, 16'h0);
      // R7/R8/R9 system call, then a call offered during the stall
      step(1'b1, 16'hF025, 16'h3012, 16'h0, 3'b001, 16'h0BEE);
      step(1'b1, 16'h4805, 16'h3013, 16'h0, 3'b001, 16'h0400);
      step(1'b0, 16'h0000, 16'h3013, 16'h0, 3'b001, 16'h0);
      // back-to-back system calls: the second starts after the stall
      step(1'b1, 16'hF0FF, 16'h3020, 16'h0, 3'b100, 16'h0);
      step(1'b0, 16'h0000, 16'h3021, 16'h0, 3'b100, 16'h1234);
      step(1'b1, 16'hF000, 16'h3022, 16'h0, 3'b100, 16'h0);
      step(1'b0, 16'h0000, 16'h3023, 16'h0, 3'b100, 16'hABCD);
      // R10 unrelated opcode
      step(1'b1, 16'h1261, 16'h3030, 16'h7777, 3'b010, 16'h0);
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 5) != 0, rand_instr(), 16'($urandom), 16'($urandom),
              rand_flags(), 16'($urandom));
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule